// File: doc/BRIEF.md
# Idle Handshake and Reset Front End

This block sits between a power manager, a register bus and the functional core of a peripheral. It holds one small configuration register that chooses how idle requests are answered, whether the interface clock stays on while the block is idle, and whether the interface clock is gated when the bus is quiet. Writing the configuration register can also start a soft reset of the peripheral.

Idle requests are answered with a registered acknowledge. There are three policies. The first acknowledges at once. The second never acknowledges. The third waits until the core reports that it is not busy. The internal reset output is held for a fixed number of cycles after either the hardware reset or a soft reset. A status bit tells software when that internal reset has finished. The clock-enable output is registered and would drive a gating cell outside this block.

Top module: `pm_idle_rst_ctrl`

## Requirements
- R1: After reset, a read of address 0 returns 0x0A and, once the internal reset has finished, a read of address 1 returns 0x01. Address 0 is laid out as follows: bits [1:0] are the idle mode, bit 2 keeps the clock on while idle, bit 3 enables auto-gating and bit 4 is the soft-reset bit. Address 1 bit 0 is reset-done. Read data appears on the cycle after the read strobe.
- R2: In idle mode 0 (forced), `idle_ack` is high on the cycle after `idle_req` is sampled high, whatever the value of `core_busy`.
- R3: In idle mode 1 (never), `idle_ack` stays low.
- R4: In idle mode 2 (activity-based), `idle_ack` rises on the cycle after `idle_req` is high while `core_busy` is low. It then stays high while `idle_req` stays high, even if `core_busy` returns. In every mode, `idle_ack` falls on the cycle after `idle_req` is sampled low.
- R5: A write of idle mode 3 leaves the mode field unchanged, while the other fields of the same write still take effect.
- R6: A write with bit 4 set holds `core_rst` high for exactly RST_CYCLES (default 4) cycles and returns the configuration register to its reset value. Bit 4 always reads as 0.
- R7: `rst_done` is 0 while `core_rst` is high and on the first cycle after it falls, and 1 from the next cycle on. This applies after the hardware reset and after a soft reset.
- R8: Writes to the configuration register while `core_rst` is high are ignored.
- R9: With auto-gating at 0, `clk_en` is 1. With auto-gating at 1 and no idle acknowledge, `clk_en` is 1 on the cycle after a bus access and 0 on the cycle after a cycle with no access.
- R10: While `idle_ack` is high, `clk_en` follows the keep-clock bit, one cycle later. While `core_rst` is high, `clk_en` is 1 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address (0 is configuration, 1 is status) |
| wdata | input | 5 | Write data |
| rdata | output | 5 | Read data, valid on the cycle after `rd_en` |
| idle_req | input | 1 | Idle request from the power manager |
| core_busy | input | 1 | The functional core has work in progress |
| idle_ack | output | 1 | Idle acknowledge |
| core_rst | output | 1 | Internal reset to the functional core |
| rst_done | output | 1 | Internal reset has completed |
| clk_en | output | 1 | Enable for the interface clock gate |

## Verification
Each output has a fixed latency:
- `idle_ack` settles one cycle after the request or busy change that causes it.
- `clk_en` settles one cycle after its cause, so it comes two cycles after a request when it is driven through the acknowledge.
- `rdata` is valid one cycle after the read strobe.
- `core_rst` stays high for RST_CYCLES cycles after the triggering edge.
- `rst_done` returns one cycle after `core_rst` falls.

The bench drives every input on the falling edge and samples on a later falling edge. It counts the exact number of rising edges between cause and check, so each result is read in the cycle it is due and not merely once it has settled. For the soft reset it checks the last cycle with `core_rst` high, the release cycle and the cycle after it, so a pulse one cycle too long or too short is reported.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int REG_W      = 5;
  localparam int B_MODE     = 0;
  localparam int B_CLKACT   = 2;
  localparam int B_AUTOGATE = 3;
  localparam int B_SOFTRST  = 4;

  typedef enum logic [1:0] {
    MODE_FORCE = 2'd0,
    MODE_NEVER = 2'd1,
    MODE_SMART = 2'd2,
    MODE_RSVD  = 2'd3
  } idle_mode_e;

  typedef struct packed {
    logic       auto_gate;
    logic       clk_act;
    idle_mode_e mode;
  } pm_cfg_t;

  localparam pm_cfg_t CFG_DEFAULT = '{auto_gate: 1'b1, clk_act: 1'b0, mode: MODE_SMART};
endpackage

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_rst,
  input  logic              rst_done,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output pm_cfg_t           cfg,
  output logic              soft_start
);
  localparam logic [ADDR_W-1:0] A_CFG  = '0;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

  logic             wr_cfg;
  idle_mode_e       wmode;
  logic [REG_W-1:0] rd_mux;

  assign wr_cfg     = wr_en && (addr == A_CFG) && !core_rst;
  assign soft_start = wr_cfg && wdata[B_SOFTRST];
  assign wmode      = idle_mode_e'(wdata[B_MODE +: 2]);

  always_ff @(posedge clk) begin
    if (rst || soft_start) begin
      cfg <= CFG_DEFAULT;
    end else if (wr_cfg) begin
      cfg.auto_gate <= wdata[B_AUTOGATE];
      cfg.clk_act   <= wdata[B_CLKACT];
      if (wmode != MODE_RSVD) cfg.mode <= wmode;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_CFG) begin
      rd_mux[B_MODE +: 2] = cfg.mode;
      rd_mux[B_CLKACT]    = cfg.clk_act;
      rd_mux[B_AUTOGATE]  = cfg.auto_gate;
    end else if (addr == A_STAT) begin
      rd_mux[0] = rst_done;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/irc_rst_seq.sv
module irc_rst_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic core_rst,
  output logic rst_done
);
  localparam int             CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] INIT = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst <= 1'b1;
      cnt_q    <= INIT;
      rst_done <= 1'b0;
    end else begin
      if (start && !core_rst) begin
        core_rst <= 1'b1;
        cnt_q    <= INIT;
      end else if (core_rst) begin
        if (cnt_q == '0) core_rst <= 1'b0;
        else             cnt_q    <= cnt_q - 1'b1;
      end
      rst_done <= !core_rst && !start;
    end
  end
endmodule

// File: rtl/irc_idle_hs.sv
module irc_idle_hs
  import irc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       core_rst,
  input  idle_mode_e mode,
  input  logic       idle_req,
  input  logic       core_busy,
  output logic       idle_ack
);
  logic ack_nxt;

  always_comb begin
    unique case (mode)
      MODE_FORCE: ack_nxt = idle_req;
      MODE_NEVER: ack_nxt = 1'b0;
      MODE_SMART: ack_nxt = idle_req && (idle_ack || !core_busy);
      default:    ack_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || core_rst) idle_ack <= 1'b0;
    else                 idle_ack <= ack_nxt;
  end
endmodule

// File: rtl/irc_clk_gate.sv
module irc_clk_gate (
  input  logic clk,
  input  logic rst,
  input  logic core_rst,
  input  logic idle_ack,
  input  logic clk_act,
  input  logic auto_gate,
  input  logic bus_access,
  output logic clk_en
);
  always_ff @(posedge clk) begin
    if (rst || core_rst) clk_en <= 1'b1;
    else if (idle_ack)   clk_en <= clk_act;
    else                 clk_en <= !auto_gate || bus_access;
  end
endmodule

// File: rtl/pm_idle_rst_ctrl.sv
module pm_idle_rst_ctrl
  import irc_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              idle_req,
  input  logic              core_busy,
  output logic              idle_ack,
  output logic              core_rst,
  output logic              rst_done,
  output logic              clk_en
);
  pm_cfg_t cfg;
  logic    soft_start;

  irc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .core_rst(core_rst), .rst_done(rst_done),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cfg(cfg), .soft_start(soft_start)
  );

  irc_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(soft_start),
    .core_rst(core_rst), .rst_done(rst_done)
  );

  irc_idle_hs u_hs (
    .clk(clk), .rst(rst), .core_rst(core_rst), .mode(cfg.mode),
    .idle_req(idle_req), .core_busy(core_busy), .idle_ack(idle_ack)
  );

  irc_clk_gate u_gate (
    .clk(clk), .rst(rst), .core_rst(core_rst), .idle_ack(idle_ack),
    .clk_act(cfg.clk_act), .auto_gate(cfg.auto_gate),
    .bus_access(wr_en || rd_en), .clk_en(clk_en)
  );
endmodule

// File: rtl/pm_idle_rst_ctrl_chk.sv
module pm_idle_rst_ctrl_chk
  import irc_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input logic    clk,
  input logic    rst,
  input logic    idle_req,
  input logic    core_busy,
  input logic    idle_ack,
  input logic    core_rst,
  input logic    rst_done,
  input logic    clk_en,
  input pm_cfg_t cfg
);
  localparam int RUN_W = $clog2(RST_CYCLES + 1) + 1;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)           run <= '0;
    else if (core_rst) run <= run + 1'b1;
    else               run <= '0;
  end

  p_force_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_FORCE && idle_req && !core_rst) |=> idle_ack);
  p_never_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_NEVER) |=> !idle_ack);
  p_smart_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_SMART && core_busy && !idle_ack) |=> !idle_ack);
  p_req_drop_r4: assert property (@(posedge clk) disable iff (rst)
    !idle_req |=> !idle_ack);
  p_mode_legal_r5: assert property (@(posedge clk) disable iff (rst)
    cfg.mode != MODE_RSVD);
  p_rst_len_r6: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> (run < RUN_W'(RST_CYCLES)));
  p_rst_full_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (run == RUN_W'(RST_CYCLES)));
  p_done_low_r7: assert property (@(posedge clk) disable iff (rst)
    (core_rst || $fell(core_rst)) |-> !rst_done);
  p_done_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_done) |-> !$past(core_rst));
  p_gate_free_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg.auto_gate && !idle_ack && !core_rst) |=> clk_en);
  p_gate_rst_r10: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> clk_en);
endmodule

bind pm_idle_rst_ctrl pm_idle_rst_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .idle_req(idle_req), .core_busy(core_busy),
  .idle_ack(idle_ack), .core_rst(core_rst), .rst_done(rst_done),
  .clk_en(clk_en), .cfg(cfg)
);

// File: tb/pm_idle_rst_ctrl_tb.sv
`timescale 1ns/1ps
module pm_idle_rst_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [4:0] wdata = '0;
  logic [4:0] rdata;
  logic       idle_req = 1'b0, core_busy = 1'b0;
  logic       idle_ack, core_rst, rst_done, clk_en;
  int         n_chk = 0, n_fail = 0;
  bit         ended = 1'b0;

  always #5 clk = ~clk;

  pm_idle_rst_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .idle_req(idle_req), .core_busy(core_busy),
    .idle_ack(idle_ack), .core_rst(core_rst), .rst_done(rst_done), .clk_en(clk_en)
  );

  // {mode[1:0], idle_req, core_busy, expected ack}
  localparam logic [4:0] VEC [8] = '{
    {2'd0, 1'b1, 1'b0, 1'b1}, {2'd0, 1'b1, 1'b1, 1'b1},
    {2'd1, 1'b1, 1'b0, 1'b0}, {2'd1, 1'b1, 1'b1, 1'b0},
    {2'd2, 1'b1, 1'b1, 1'b0}, {2'd0, 1'b0, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0}, {2'd2, 1'b1, 1'b0, 1'b1}
  };

  function automatic string tag_of(input logic [1:0] m);
    if (m == 2'd0) return "R2";
    if (m == 2'd1) return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [4:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  initial begin
    logic [4:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // hardware reset release: internal reset still held on the third edge
    repeat (3) @(negedge clk);
    check("R7 core_rst held after hw reset", {7'd0, core_rst}, 8'd1);
    check("R7 done low during reset", {7'd0, rst_done}, 8'd0);
    check("R10 clk_en on during reset", {7'd0, clk_en}, 8'd1);
    @(negedge clk);
    check("R7 core_rst released", {7'd0, core_rst}, 8'd0);
    check("R7 done still low at release", {7'd0, rst_done}, 8'd0);
    @(negedge clk);
    check("R7 done high", {7'd0, rst_done}, 8'd1);

    rd(2'd0, d); check("R1 config reset value", {3'd0, d}, 8'h0A);
    rd(2'd1, d); check("R1 status done", {3'd0, d}, 8'h01);
    check("R9 clk_en after access", {7'd0, clk_en}, 8'd1);
    @(negedge clk);
    check("R9 clk_en gated when quiet", {7'd0, clk_en}, 8'd0);

    // table-driven idle policy
    for (int i = 0; i < 8; i++) begin
      idle_req = 1'b0; core_busy = 1'b0;
      wr(2'd0, {3'b010, VEC[i][4:3]});
      repeat (2) @(negedge clk);
      idle_req = VEC[i][2]; core_busy = VEC[i][1];
      @(negedge clk);
      check(tag_of(VEC[i][4:3]), {7'd0, idle_ack}, {7'd0, VEC[i][0]});
    end
    idle_req = 1'b0; core_busy = 1'b0;
    @(negedge clk);
    check("R4 ack falls one cycle after request drop", {7'd0, idle_ack}, 8'd0);

    // reserved mode code: mode kept, other fields written
    wr(2'd0, 5'b00111);
    rd(2'd0, d); check("R5 reserved mode ignored", {3'd0, d}, 8'h06);
    repeat (2) @(negedge clk);
    check("R9 free-running clock", {7'd0, clk_en}, 8'd1);

    // keep-clock bit while acknowledged
    wr(2'd0, 5'b01100);
    idle_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 forced ack", {7'd0, idle_ack}, 8'd1);
    check("R10 clock kept while idle", {7'd0, clk_en}, 8'd1);
    wr(2'd0, 5'b01000);
    @(negedge clk);
    check("R10 clock off while idle", {7'd0, clk_en}, 8'd0);
    idle_req = 1'b0;
    repeat (2) @(negedge clk);

    // activity-based ack: waits for busy, then holds
    wr(2'd0, 5'b01010);
    idle_req = 1'b1; core_busy = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 no ack while busy", {7'd0, idle_ack}, 8'd0);
    core_busy = 1'b0;
    @(negedge clk);
    check("R4 ack once idle", {7'd0, idle_ack}, 8'd1);
    core_busy = 1'b1;
    @(negedge clk);
    check("R4 ack held when busy returns", {7'd0, idle_ack}, 8'd1);
    idle_req = 1'b0;
    @(negedge clk);
    check("R4 ack dropped", {7'd0, idle_ack}, 8'd0);
    core_busy = 1'b0;

    // soft reset
    wr(2'd0, 5'b00001);
    rd(2'd0, d); check("R6 soft bit reads zero", {3'd0, d}, 8'h01);
    wr(2'd0, 5'b10101);
    check("R6 core_rst starts", {7'd0, core_rst}, 8'd1);
    check("R7 done cleared", {7'd0, rst_done}, 8'd0);
    wr(2'd0, 5'b00001);
    @(negedge clk);
    check("R6 core_rst last cycle", {7'd0, core_rst}, 8'd1);
    check("R10 clk_en on in soft reset", {7'd0, clk_en}, 8'd1);
    @(negedge clk);
    check("R6 core_rst released after RST_CYCLES", {7'd0, core_rst}, 8'd0);
    check("R7 done low at release", {7'd0, rst_done}, 8'd0);
    @(negedge clk);
    check("R7 done after soft reset", {7'd0, rst_done}, 8'd1);
    rd(2'd0, d); check("R8 write during reset ignored, R6 defaults", {3'd0, d}, 8'h0A);

    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule